// File: doc/BRIEF.md
# Power-Management Event and Timer Register Block

This block keeps the fixed power-management event state of a platform: a 16-bit event status register whose bits are cleared by writing ones, a 16-bit event enable register, and a 16-bit control register. It also holds a 24-bit free-running power-management timer that advances at 3.579545 MHz. That rate comes from the system clock through a fractional phase accumulator. Status bits are set by hardware sources: timer rollover of the flip bit, the power button, an RTC alarm, and the sleep logic. Any enabled event in the interrupt-capable set drives a level-sensitive SCI output.

Software reaches the registers through a small word window with a read strobe and a write strobe. A second byte-wide port carries an APM command byte and an APM scratch byte. Two command values switch the SCI-enable control bit on and off. Every command write can pulse SMI when the platform allows it. A control write with the suspend-enable bit set decodes the sleep type. Type 0 asks for soft power-off. Type 1 asks for a suspend/reset cycle and also marks the resume and power-button status bits.

Top module: `pm_event_block`

## Requirements
- R1: The timer is a CNT_W-bit (default 24) up-counter that advances by one for each accumulator carry, giving ACC_INC/ACC_MOD counts per clock; a read at offset 0x08 returns it zero-extended to 32 bits.
- R2: Reads at offset 0x00, 0x02 and 0x04 return status, enable and control, zero-extended. Any other offset reads zero, and a write to any other offset changes no register.
- R3: A write to status clears each bit written as one and leaves bits written as zero unchanged.
- R4: Status bit 0 sets on every change of timer bit FLIP_BIT (default 23), both 0→1 and 1→0.
- R5: SCI is high exactly when status AND enable has a nonzero bit among bits 0, 5, 8 and 10; bit 15 never drives SCI.
- R6: A control write stores the written value with bit 13 forced to zero.
- R7: A control write with bit 13 set and bits 12:10 equal to 0 raises softoff_req for one cycle. With bits 12:10 equal to 1, it raises suspend_req for one cycle and sets status bits 15 and 8. Other sleep types, or bit 13 clear, raise neither request.
- R8: An APM command write (apm_sel=0) of 0xF1 sets control bit 0, and one of 0xF0 clears it. Other values leave it unchanged. The last command byte reads back at apm_sel=0.
- R9: Every APM command write pulses smi_pulse for one cycle when smi_allow is high, and never when it is low.
- R10: The APM scratch byte (apm_sel=1) is a plain read/write byte and does not touch the command byte.
- R11: A pwrbtn_evt cycle sets status bit 8 only when enable bit 8 is set.
- R12: A hardware set of a status bit wins over a software clear of that bit in the same cycle.
- R13: An rtc_evt cycle sets status bit 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset into the register window |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe; read data is zero when low |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| apm_sel | input | 1 | APM port select: 0 command, 1 scratch |
| apm_wdata | input | 8 | APM write byte |
| apm_we | input | 1 | APM write strobe |
| apm_rdata | output | 8 | Selected APM byte |
| smi_allow | input | 1 | Permits SMI pulses on command writes |
| pwrbtn_evt | input | 1 | Power-button event, one cycle |
| rtc_evt | input | 1 | RTC alarm event, one cycle |
| sci | output | 1 | Level-sensitive SCI request |
| smi_pulse | output | 1 | One-cycle SMI pulse |
| softoff_req | output | 1 | One-cycle soft power-off request |
| suspend_req | output | 1 | One-cycle suspend/reset request |

## Verification
The hardest case is R12. A software clear of the timer status bit has to land on exactly the clock edge where the timer flip bit changes, and that phase cannot be set from the ports. The stimulus therefore polls the timer through the bus until its low bits show the edge that comes just before a flip. It then issues the clearing write so that it lands on that edge. The same polling places clears away from a flip, to show the rise of the bit at the predicted cycle for R4. The bench builds the block with a one-count-per-clock accumulator and a low flip bit to keep runs short. A second instance, built with the default parameters, checks the fractional rate over 2000 cycles.

// File: rtl/pmev_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and types of the power-management event block.
// Assumes a 16-bit register word; offsets are byte offsets in the window.
package pmev_pkg;
    localparam int unsigned REG_W      = 16;
    localparam int unsigned OFS_STS    = 'h00;
    localparam int unsigned OFS_EN     = 'h02;
    localparam int unsigned OFS_CTL    = 'h04;
    localparam int unsigned OFS_TMR    = 'h08;

    localparam int unsigned ST_TMR     = 0;
    localparam int unsigned ST_PWR     = 8;
    localparam int unsigned ST_RTC     = 10;
    localparam int unsigned ST_RSM     = 15;

    localparam int unsigned CTL_SCIEN  = 0;
    localparam int unsigned CTL_SUSEN  = 13;
    localparam int unsigned CTL_SLP_LO = 10;

    localparam logic [REG_W-1:0] SCI_MASK = 16'h0521;
    localparam logic [7:0] APM_SCI_ON  = 8'hF1;
    localparam logic [7:0] APM_SCI_OFF = 8'hF0;

    typedef enum logic [1:0] {
        SLP_NONE    = 2'd0,
        SLP_SOFTOFF = 2'd1,
        SLP_SUSPEND = 2'd2
    } sleep_act_e;

    // Map a control write word to the sleep action it requests.
    function automatic sleep_act_e slp_decode(input logic [REG_W-1:0] w);
        sleep_act_e a;
        a = SLP_NONE;
        if (w[CTL_SUSEN]) begin
            case (w[CTL_SLP_LO +: 3])
                3'd0:    a = SLP_SOFTOFF;
                3'd1:    a = SLP_SUSPEND;
                default: a = SLP_NONE;
            endcase
        end
        return a;
    endfunction
endpackage

// File: rtl/pmev_timer.sv
`timescale 1ns/1ps
// Module: power-management timer.
// A fractional phase accumulator adds ACC_INC each clock and carries at
// ACC_MOD; each carry advances a CNT_W-bit counter. flip_evt marks the
// cycle whose carry changes bit FLIP_BIT. Assumes ACC_INC <= ACC_MOD and
// 1 <= FLIP_BIT < CNT_W.
module pmev_timer #(
    parameter int unsigned ACC_INC  = 3579545,
    parameter int unsigned ACC_MOD  = 50000000,
    parameter int unsigned CNT_W    = 24,
    parameter int unsigned FLIP_BIT = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] count,
    output logic             flip_evt
);
    localparam int unsigned ACC_W = $clog2(ACC_MOD + ACC_INC) + 1;

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] acc_sum;
    logic             tick;

    // Carry detection of the phase accumulator.
    always_comb begin
        acc_sum  = acc + ACC_W'(ACC_INC);
        tick     = (acc_sum >= ACC_W'(ACC_MOD));
        flip_evt = tick && (&count[FLIP_BIT-1:0]);
    end

    // Accumulator and counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc   <= '0;
            count <= '0;
        end else begin
            acc <= tick ? (acc_sum - ACC_W'(ACC_MOD)) : acc_sum;
            if (tick) count <= count + 1'b1;
        end
    end

    assert_tmr_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (count == $past(count) + 1'b1));
    assert_tmr_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count));
endmodule

// File: rtl/pmev_apm.sv
`timescale 1ns/1ps
// Module: APM byte port.
// Holds the command and scratch bytes, flags the two SCI-enable commands
// for the register file, and issues a one-cycle SMI pulse per command
// write when permitted.
module pmev_apm
    import pmev_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel,
    input  logic [7:0] wdata,
    input  logic       we,
    input  logic       smi_allow,
    output logic [7:0] rdata,
    output logic       sci_on,
    output logic       sci_off,
    output logic       smi_pulse
);
    logic [7:0] cmd_q;
    logic [7:0] scratch_q;
    logic       cmd_we;

    // Command write decode.
    always_comb begin
        cmd_we  = we && !sel;
        sci_on  = cmd_we && (wdata == APM_SCI_ON);
        sci_off = cmd_we && (wdata == APM_SCI_OFF);
        rdata   = sel ? scratch_q : cmd_q;
    end

    // Byte storage and SMI pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q     <= '0;
            scratch_q <= '0;
            smi_pulse <= 1'b0;
        end else begin
            if (cmd_we) cmd_q <= wdata;
            if (we && sel) scratch_q <= wdata;
            smi_pulse <= cmd_we && smi_allow;
        end
    end

    assert_smi_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        smi_pulse |-> $past(smi_allow && we && !sel));
    assert_scratch_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel) |=> $stable(cmd_q));
endmodule

// File: rtl/pmev_regs.sv
`timescale 1ns/1ps
// Module: status, enable and control registers.
// Status bits are write-one-to-clear with hardware sets taking priority;
// the control word drops its suspend-enable bit and its sleep type is
// decoded into one-cycle requests. SCI is a level from registered state.
module pmev_regs
    import pmev_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              we,
    input  logic              ovf_evt,
    input  logic              pwrbtn_evt,
    input  logic              rtc_evt,
    input  logic              sci_on,
    input  logic              sci_off,
    output logic [REG_W-1:0]  status,
    output logic [REG_W-1:0]  enable,
    output logic [REG_W-1:0]  control,
    output logic              sci,
    output logic              softoff_req,
    output logic              suspend_req
);
    logic             wr_sts, wr_en, wr_ctl;
    sleep_act_e       slp_act;
    logic [REG_W-1:0] set_vec, clr_vec, ctl_nxt;

    // Write decode and per-bit set/clear vectors.
    always_comb begin
        wr_sts  = we && (addr == ADDR_W'(OFS_STS));
        wr_en   = we && (addr == ADDR_W'(OFS_EN));
        wr_ctl  = we && (addr == ADDR_W'(OFS_CTL));
        slp_act = wr_ctl ? slp_decode(wdata) : SLP_NONE;
        clr_vec = wr_sts ? wdata : '0;
        set_vec = '0;
        set_vec[ST_TMR] = ovf_evt;
        set_vec[ST_PWR] = (pwrbtn_evt && enable[ST_PWR]) || (slp_act == SLP_SUSPEND);
        set_vec[ST_RTC] = rtc_evt;
        set_vec[ST_RSM] = (slp_act == SLP_SUSPEND);
    end

    // One status cell per bit: set beats clear.
    for (genvar b = 0; b < REG_W; b++) begin : g_sts
        always_ff @(posedge clk) begin
            if (!rst_n)          status[b] <= 1'b0;
            else if (set_vec[b]) status[b] <= 1'b1;
            else if (clr_vec[b]) status[b] <= 1'b0;
        end
    end

    // Next control word: bus write first, APM command on top.
    always_comb begin
        ctl_nxt = control;
        if (wr_ctl) begin
            ctl_nxt = wdata;
            ctl_nxt[CTL_SUSEN] = 1'b0;
        end
        if (sci_on)  ctl_nxt[CTL_SCIEN] = 1'b1;
        if (sci_off) ctl_nxt[CTL_SCIEN] = 1'b0;
    end

    // Enable, control and request registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable      <= '0;
            control     <= '0;
            softoff_req <= 1'b0;
            suspend_req <= 1'b0;
        end else begin
            if (wr_en) enable <= wdata;
            control     <= ctl_nxt;
            softoff_req <= (slp_act == SLP_SOFTOFF);
            suspend_req <= (slp_act == SLP_SUSPEND);
        end
    end

    // Interrupt level.
    always_comb sci = |(status & enable & SCI_MASK);

    assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sts && wdata[ST_PWR] && !pwrbtn_evt) |=> !status[ST_PWR]);
    assert_sci_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sci |-> |(enable & SCI_MASK));
    assert_susen_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctl |=> !control[CTL_SUSEN]);
    assert_resume_mark_R7: assert property (@(posedge clk) disable iff (!rst_n)
        suspend_req |-> (status[ST_RSM] && status[ST_PWR]));
    assert_req_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({softoff_req, suspend_req}) <= 1);
    assert_pwr_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pwrbtn_evt && !enable[ST_PWR] && !status[ST_PWR] && !wr_ctl) |=> !status[ST_PWR]);
    assert_hw_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> status[ST_TMR]);
    assert_rtc_set_R13: assert property (@(posedge clk) disable iff (!rst_n)
        rtc_evt |=> status[ST_RTC]);
endmodule

// File: rtl/pm_event_block.sv
`timescale 1ns/1ps
// Module: power-management event block top.
// Joins the timer, the register file and the APM port, and muxes the
// register window onto the 32-bit read data. Assumes single-cycle
// strobes; read data is combinational and zero without a read strobe.
module pm_event_block
    import pmev_pkg::*;
#(
    parameter int unsigned ADDR_W   = 6,
    parameter int unsigned ACC_INC  = 3579545,
    parameter int unsigned ACC_MOD  = 50000000,
    parameter int unsigned CNT_W    = 24,
    parameter int unsigned FLIP_BIT = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [31:0]       bus_rdata,
    input  logic              apm_sel,
    input  logic [7:0]        apm_wdata,
    input  logic              apm_we,
    output logic [7:0]        apm_rdata,
    input  logic              smi_allow,
    input  logic              pwrbtn_evt,
    input  logic              rtc_evt,
    output logic              sci,
    output logic              smi_pulse,
    output logic              softoff_req,
    output logic              suspend_req
);
    logic [CNT_W-1:0] tmr_count;
    logic             tmr_flip;
    logic             sci_on, sci_off;
    logic [REG_W-1:0] status, enable, control;

    pmev_timer #(
        .ACC_INC(ACC_INC), .ACC_MOD(ACC_MOD), .CNT_W(CNT_W), .FLIP_BIT(FLIP_BIT)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .count(tmr_count), .flip_evt(tmr_flip)
    );

    pmev_apm u_apm (
        .clk(clk), .rst_n(rst_n), .sel(apm_sel), .wdata(apm_wdata), .we(apm_we),
        .smi_allow(smi_allow), .rdata(apm_rdata), .sci_on(sci_on),
        .sci_off(sci_off), .smi_pulse(smi_pulse)
    );

    pmev_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata),
        .we(bus_we), .ovf_evt(tmr_flip), .pwrbtn_evt(pwrbtn_evt),
        .rtc_evt(rtc_evt), .sci_on(sci_on), .sci_off(sci_off),
        .status(status), .enable(enable), .control(control), .sci(sci),
        .softoff_req(softoff_req), .suspend_req(suspend_req)
    );

    // Register window read mux.
    always_comb begin
        bus_rdata = '0;
        if (bus_re) begin
            if (bus_addr == ADDR_W'(OFS_STS))      bus_rdata = 32'(status);
            else if (bus_addr == ADDR_W'(OFS_EN))  bus_rdata = 32'(enable);
            else if (bus_addr == ADDR_W'(OFS_CTL)) bus_rdata = 32'(control);
            else if (bus_addr == ADDR_W'(OFS_TMR)) bus_rdata = 32'(tmr_count);
        end
    end

    assert_sci_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (apm_we && !apm_sel && apm_wdata == APM_SCI_ON) |=> control[CTL_SCIEN]);
endmodule

// File: tb/pm_event_block_test.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expectations, a monitor compares
// them 5 ns after each falling edge.
module pm_event_block_test;
    logic        clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_we = 1'b0, bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic        apm_sel = 1'b0, apm_we = 1'b0;
    logic [7:0]  apm_wdata = '0, apm_rdata;
    logic        smi_allow = 1'b0, pwrbtn_evt = 1'b0, rtc_evt = 1'b0;
    logic        sci, smi_pulse, softoff_req, suspend_req;

    pm_event_block #(.ACC_INC(1), .ACC_MOD(1), .FLIP_BIT(4)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .apm_sel(apm_sel), .apm_wdata(apm_wdata), .apm_we(apm_we),
        .apm_rdata(apm_rdata), .smi_allow(smi_allow), .pwrbtn_evt(pwrbtn_evt),
        .rtc_evt(rtc_evt), .sci(sci), .smi_pulse(smi_pulse),
        .softoff_req(softoff_req), .suspend_req(suspend_req)
    );

    logic [31:0] r_rdata;
    logic [7:0]  r_apm;
    logic        r_sci, r_smi, r_off, r_sus;
    pm_event_block uut_rate (
        .clk(clk), .rst_n(rst_n), .bus_addr(6'h08), .bus_wdata(16'h0),
        .bus_we(1'b0), .bus_re(1'b1), .bus_rdata(r_rdata),
        .apm_sel(1'b0), .apm_wdata(8'h0), .apm_we(1'b0), .apm_rdata(r_apm),
        .smi_allow(1'b0), .pwrbtn_evt(1'b0), .rtc_evt(1'b0), .sci(r_sci),
        .smi_pulse(r_smi), .softoff_req(r_off), .suspend_req(r_sus)
    );

    typedef enum {K_RD, K_APM, K_SCI, K_SMI, K_OFF, K_SUS} kind_e;
    typedef struct {
        kind_e       k;
        logic [31:0] exp;
        logic [31:0] mask;
        string       tag;
    } item_t;
    item_t sbq[$];
    int n_chk = 0;
    int n_fail = 0;

    function automatic void judge(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endfunction

    // Monitor: compare every queued item at falling edge + 5 ns.
    always @(negedge clk) begin
        #5;
        while (sbq.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sbq.pop_front();
            case (it.k)
                K_RD:    act = bus_rdata;
                K_APM:   act = 32'(apm_rdata);
                K_SCI:   act = 32'(sci);
                K_SMI:   act = 32'(smi_pulse);
                K_OFF:   act = 32'(softoff_req);
                default: act = 32'(suspend_req);
            endcase
            judge(it.tag, act & it.mask, it.exp);
        end
    end

    task automatic push(kind_e k, logic [31:0] exp, logic [31:0] mask, string tag);
        item_t it;
        it.k = k; it.exp = exp; it.mask = mask; it.tag = tag;
        sbq.push_back(it);
    endtask

    task automatic obs(kind_e k, logic [31:0] exp, string tag);
        push(k, exp, 32'hFFFF_FFFF, tag);
    endtask

    task automatic bus_wr(logic [5:0] a, logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1; bus_re = 1'b0;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_exp(logic [5:0] a, logic [31:0] exp, logic [31:0] mask, string tag);
        bus_addr = a; bus_re = 1'b1;
        push(K_RD, exp, mask, tag);
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic apm_wr(logic s, logic [7:0] d);
        apm_sel = s; apm_wdata = d; apm_we = 1'b1;
        @(negedge clk);
        apm_we = 1'b0;
    endtask

    task automatic apm_rd(logic s, logic [7:0] exp, string tag);
        apm_sel = s;
        push(K_APM, 32'(exp), 32'hFFFF_FFFF, tag);
        @(negedge clk);
    endtask

    task automatic tmr_sample(output logic [31:0] v);
        bus_addr = 6'h08; bus_re = 1'b1;
        #1 v = bus_rdata;
        bus_re = 1'b0;
    endtask

    // Wait at falling edges until the fast timer's low nibble equals ph.
    task automatic wait_phase(logic [3:0] ph);
        logic [31:0] v;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            tmr_sample(v);
            if (v[3:0] == ph) break;
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #(20 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] t0, t1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // Reset state
        rd_exp(6'h00, 32'h0, 32'hFFFF_FFFE, "R2 reset status");
        rd_exp(6'h02, 32'h0, 32'hFFFF_FFFF, "R2 reset enable");
        rd_exp(6'h04, 32'h0, 32'hFFFF_FFFF, "R2 reset control");
        obs(K_SCI, 0, "R5 reset sci");
        obs(K_OFF, 0, "R7 reset softoff");
        obs(K_SUS, 0, "R7 reset suspend");
        obs(K_SMI, 0, "R9 reset smi");

        // R1: one count per clock with the bench parameters
        tmr_sample(t0);
        repeat (10) @(negedge clk);
        rd_exp(6'h08, (t0 + 10) & 32'h00FF_FFFF, 32'hFFFF_FFFF, "R1 timer step");
        // R1: fractional rate on the default instance, 2000 clocks
        tmr_sample(t0);
        t0 = r_rdata;
        repeat (2000) @(negedge clk);
        #1 t1 = r_rdata;
        judge("R1 fractional rate", 32'((t1 - t0 == 143) || (t1 - t0 == 144)), 32'h1);
        @(negedge clk);

        // R2: unlisted offsets
        rd_exp(6'h0C, 32'h0, 32'hFFFF_FFFF, "R2 unlisted read");
        bus_wr(6'h06, 16'hFFFF);
        rd_exp(6'h02, 32'h0, 32'hFFFF_FFFF, "R2 stray write enable");
        rd_exp(6'h04, 32'h0, 32'hFFFF_FFFF, "R2 stray write control");

        // R6 / R7: sleep type 7 with suspend-enable
        bus_wr(6'h04, 16'h3C05);
        obs(K_OFF, 0, "R7 type7 no softoff");
        obs(K_SUS, 0, "R7 type7 no suspend");
        rd_exp(6'h04, 32'h1C05, 32'hFFFF_FFFF, "R6 control drops bit13");
        bus_wr(6'h04, 16'h0000);
        obs(K_OFF, 0, "R7 type0 without susen");
        rd_exp(6'h04, 32'h0, 32'hFFFF_FFFF, "R6 control cleared");

        // R8: APM SCI-enable commands
        apm_wr(1'b0, 8'hF1);
        rd_exp(6'h04, 32'h1, 32'hFFFF_FFFF, "R8 F1 sets sci_en");
        apm_wr(1'b0, 8'h55);
        rd_exp(6'h04, 32'h1, 32'hFFFF_FFFF, "R8 other value keeps");
        apm_rd(1'b0, 8'h55, "R8 command readback");
        apm_wr(1'b0, 8'hF0);
        rd_exp(6'h04, 32'h0, 32'hFFFF_FFFF, "R8 F0 clears sci_en");

        // R9: SMI pulse gating
        smi_allow = 1'b1;
        apm_wr(1'b0, 8'h33);
        obs(K_SMI, 1, "R9 smi pulse");
        @(negedge clk);
        obs(K_SMI, 0, "R9 smi one cycle");
        smi_allow = 1'b0;
        apm_wr(1'b0, 8'h34);
        obs(K_SMI, 0, "R9 smi blocked");

        // R10: scratch byte
        apm_wr(1'b1, 8'h5A);
        apm_rd(1'b1, 8'h5A, "R10 scratch readback");
        apm_rd(1'b0, 8'h34, "R10 command untouched");

        // R11 / R3 / R5: power button
        pwrbtn_evt = 1'b1; @(negedge clk); pwrbtn_evt = 1'b0;
        rd_exp(6'h00, 32'h0, 32'h0100, "R11 button blocked");
        bus_wr(6'h02, 16'h0100);
        pwrbtn_evt = 1'b1; @(negedge clk); pwrbtn_evt = 1'b0;
        obs(K_SCI, 1, "R5 sci on button");
        rd_exp(6'h00, 32'h0100, 32'h0100, "R11 button sets");
        bus_wr(6'h00, 16'h0000);
        rd_exp(6'h00, 32'h0100, 32'h0100, "R3 zero write keeps");
        bus_wr(6'h00, 16'h0100);
        obs(K_SCI, 0, "R5 sci drops");
        rd_exp(6'h00, 32'h0, 32'h0100, "R3 one write clears");

        // R13 / R5: RTC event
        rtc_evt = 1'b1; @(negedge clk); rtc_evt = 1'b0;
        obs(K_SCI, 0, "R5 rtc not enabled");
        rd_exp(6'h00, 32'h0400, 32'hFFFF_FFFE, "R13 rtc sets");
        bus_wr(6'h02, 16'h0400);
        obs(K_SCI, 1, "R5 rtc enabled");
        bus_wr(6'h00, 16'h0400);

        // R7: soft-off and suspend
        bus_wr(6'h04, 16'h2000);
        obs(K_OFF, 1, "R7 softoff pulse");
        obs(K_SUS, 0, "R7 softoff no suspend");
        @(negedge clk);
        obs(K_OFF, 0, "R7 softoff one cycle");
        bus_wr(6'h02, 16'h8000);
        bus_wr(6'h04, 16'h2400);
        obs(K_SUS, 1, "R7 suspend pulse");
        obs(K_OFF, 0, "R7 suspend no softoff");
        rd_exp(6'h00, 32'h8100, 32'hFFFF_FFFE, "R7 resume marks");
        obs(K_SUS, 0, "R7 suspend one cycle");
        obs(K_SCI, 0, "R5 bit15 excluded");
        bus_wr(6'h00, 16'hFFFF);
        rd_exp(6'h00, 32'h0, 32'hFFFF_FFFE, "R3 clear all");

        // R4: timer flip sets status bit 0 at the predicted edge
        bus_wr(6'h02, 16'h0001);
        wait_phase(4'd2);
        bus_wr(6'h00, 16'h0001);
        rd_exp(6'h00, 32'h0, 32'h1, "R4 cleared before flip");
        repeat (11) @(negedge clk);
        rd_exp(6'h00, 32'h0, 32'h1, "R4 not yet set");
        obs(K_SCI, 1, "R5 sci on timer flip");
        rd_exp(6'h00, 32'h1, 32'h1, "R4 set on flip");

        // R12: clear on the flip edge loses to the hardware set
        wait_phase(4'd5);
        bus_wr(6'h00, 16'h0001);
        rd_exp(6'h00, 32'h0, 32'h1, "R4 cleared between flips");
        wait_phase(4'd15);
        bus_wr(6'h00, 16'h0001);
        rd_exp(6'h00, 32'h1, 32'h1, "R12 set beats clear");
        bus_wr(6'h02, 16'h0000);
        obs(K_SCI, 0, "R5 sci off with no enables");

        @(negedge clk);
        @(negedge clk);
        summary();
        $finish;
    end
endmodule